// File: doc/BRIEF.md
# Small-Secret Shift-Add Multiply-Accumulate Lane

This block is one multiply-accumulate lane for schoolbook polynomial multiplication over a power-of-two modulus. Each step adds to an accumulator coefficient the product of a public coefficient and a small signed secret coefficient. The secret's magnitude never exceeds five, so the lane uses no multiplier. It forms the product from the public value, the value shifted left by one, and the value shifted left by two. It adds at most two of these and negates the result when the secret is negative. The sum is truncated to `Q_W` bits, and that truncation is the whole modular reduction.

A mode input selects a dual-term step. In that step a second public/secret pair is added in the same cycle, so a row of lanes consumes two secret coefficients per cycle. An optional output register, chosen by parameter, holds the new accumulator value. When the register is present, it loads only on cycles where the enable is high. Rotating the public polynomial, storing coefficients and sequencing the outer loop are left to the surrounding datapath.

Top module: `small_secret_mac_lane`

## Requirements
- R1: A secret is 4 bits in sign-magnitude form. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. In single-term mode the lane produces (acc_in + s0*pub0) mod 2^Q_W.
- R2: Magnitudes 1 to 5 give products x, 2x, 3x, 4x and 5x of the public coefficient x. A negative sign subtracts that product from the accumulator.
- R3: A magnitude of 0, 6 or 7 contributes nothing, whatever the sign bit.
- R4: The secret 4'b1000 (negative zero) leaves the accumulator unchanged.
- R5: With `dual_en` high, the lane produces (acc_in + s0*pub0 + s1*pub1) mod 2^Q_W in one step. The second term follows the same secret rules as the first.
- R6: With `dual_en` low, `pub1` and `sec1` have no effect on the result.
- R7: Sums that exceed 2^Q_W-1 or fall below zero wrap modulo 2^Q_W. No further reduction is applied.
- R8: With the output register present, `acc_out` is 0 while `rst_n` is low.
- R9: With the output register present, `acc_out` takes the new value on the clock edge after a cycle with `en` high. It holds its value while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output register |
| dual_en | input | 1 | Add the second product term |
| pub0 | input | Q_W | First public coefficient |
| sec0 | input | 4 | First secret, sign-magnitude |
| pub1 | input | Q_W | Second public coefficient |
| sec1 | input | 4 | Second secret, sign-magnitude |
| acc_in | input | Q_W | Current accumulator coefficient |
| acc_out | output | Q_W | Updated accumulator coefficient |

## Verification
The bench tries every secret code with several random public and accumulator values, in both modes. In dual mode it crosses all 256 pairs of secret codes. A decoder with a wrong shift pattern for 3 or 5, or one that lets codes 6 and 7 through, would show a wrong coefficient for those codes only. Negative zero is checked on its own: a lane that negated zero carelessly, or ignored the sign on the zero code, would move the accumulator. Directed cases drive sums past 2^Q_W-1 and below zero, change the second pair while single mode is selected, and drop the enable. These catch a lane that reduces instead of truncating, leaks the second term, or loads while disabled.

// File: rtl/sslane_pkg.sv
package sslane_pkg;
  localparam int SEC_W   = 4;
  localparam int MAG_W   = SEC_W - 1;
  localparam int MAG_MAX = 5;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } secret_t;
endpackage

// File: rtl/sslane_term.sv
module sslane_term
  import sslane_pkg::*;
#(
  parameter int W = 13
) (
  input  logic [W-1:0] pub,
  input  secret_t      sec,
  output logic [W-1:0] term
);
  logic [W-1:0] x1, x2, x4, mag_prod;

  assign x1 = pub;
  assign x2 = {pub[W-2:0], 1'b0};
  assign x4 = {pub[W-3:0], 2'b00};

  always_comb begin
    case (sec.mag)
      3'd1:    mag_prod = x1;
      3'd2:    mag_prod = x2;
      3'd3:    mag_prod = x1 + x2;
      3'd4:    mag_prod = x4;
      3'd5:    mag_prod = x1 + x4;
      default: mag_prod = '0;
    endcase
  end

  // two's-complement negate; a zero product stays zero
  assign term = sec.neg ? ((~mag_prod) + {{(W-1){1'b0}}, 1'b1}) : mag_prod;
endmodule

// File: rtl/sslane_sum.sv
module sslane_sum #(
  parameter int W = 13
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] t0,
  input  logic [W-1:0] t1,
  input  logic         use_t1,
  output logic [W-1:0] sum
);
  logic [W-1:0] t1_gated;

  assign t1_gated = use_t1 ? t1 : '0;
  assign sum      = acc + t0 + t1_gated;
endmodule

// File: rtl/small_secret_mac_lane.sv
module small_secret_mac_lane
  import sslane_pkg::*;
#(
  parameter int Q_W     = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dual_en,
  input  logic [Q_W-1:0]   pub0,
  input  logic [SEC_W-1:0] sec0,
  input  logic [Q_W-1:0]   pub1,
  input  logic [SEC_W-1:0] sec1,
  input  logic [Q_W-1:0]   acc_in,
  output logic [Q_W-1:0]   acc_out
);
  localparam int N_TERMS = 2;

  logic [Q_W-1:0]   pub_arr  [N_TERMS];
  logic [SEC_W-1:0] sec_arr  [N_TERMS];
  logic [Q_W-1:0]   term_arr [N_TERMS];
  logic [Q_W-1:0]   acc_nxt;

  assign pub_arr[0] = pub0;
  assign pub_arr[1] = pub1;
  assign sec_arr[0] = sec0;
  assign sec_arr[1] = sec1;

  for (genvar k = 0; k < N_TERMS; k++) begin : g_term
    sslane_term #(.W(Q_W)) u_term (
      .pub  (pub_arr[k]),
      .sec  (secret_t'(sec_arr[k])),
      .term (term_arr[k])
    );
  end

  sslane_sum #(.W(Q_W)) u_sum (
    .acc    (acc_in),
    .t0     (term_arr[0]),
    .t1     (term_arr[1]),
    .use_t1 (dual_en),
    .sum    (acc_nxt)
  );

  if (REG_OUT) begin : g_reg
    logic [Q_W-1:0] acc_q, acc_d;

    always_comb begin
      acc_d = acc_q;
      if (en) acc_d = acc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end

    assign acc_out = acc_q;
  end else begin : g_comb
    assign acc_out = acc_nxt;
  end
endmodule

// File: rtl/sslane_chk.sv
module sslane_chk
  import sslane_pkg::*;
#(
  parameter int Q_W     = 13,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dual_en,
  input logic [Q_W-1:0]   pub0,
  input logic [SEC_W-1:0] sec0,
  input logic [Q_W-1:0]   pub1,
  input logic [SEC_W-1:0] sec1,
  input logic [Q_W-1:0]   acc_in,
  input logic [Q_W-1:0]   acc_out
);
  if (REG_OUT) begin : g_props
    // R8
    reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> acc_out == '0);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(acc_out));

    // R1
    unit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !dual_en && sec0 == 4'b0001 |=> acc_out == $past(Q_W'(acc_in + pub0)));

    // R2
    unit_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !dual_en && sec0 == 4'b1001 |=> acc_out == $past(Q_W'(acc_in - pub0)));

    // R4
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !dual_en && sec0 == 4'b1000 |=> acc_out == $past(acc_in));

    // R6
    second_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !dual_en && sec0[2:0] == 3'd0 |=> acc_out == $past(acc_in));

    // R5
    dual_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && dual_en && sec0 == 4'b0000 && sec1 == 4'b0001
        |=> acc_out == $past(Q_W'(acc_in + pub1)));
  end
endmodule

bind small_secret_mac_lane sslane_chk #(.Q_W(Q_W), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .dual_en (dual_en),
  .pub0    (pub0),
  .sec0    (sec0),
  .pub1    (pub1),
  .sec1    (sec1),
  .acc_in  (acc_in),
  .acc_out (acc_out)
);

// File: tb/sim_small_secret_mac_lane.sv
`timescale 1ns/1ps
module sim_small_secret_mac_lane;
  localparam int QW   = 13;
  localparam int MASK = (1 << QW) - 1;

  logic          clk, rst_n, en, dual_en;
  logic [QW-1:0] pub0, pub1, acc_in, acc_out;
  logic [3:0]    sec0, sec1;
  int checks = 0, fails = 0;
  bit done = 0;

  small_secret_mac_lane #(.Q_W(QW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dual_en(dual_en),
    .pub0(pub0), .sec0(sec0), .pub1(pub1), .sec1(sec1),
    .acc_in(acc_in), .acc_out(acc_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int term_val(input int p, input logic [3:0] s);
    int m = int'(s[2:0]);
    if (m > 5) m = 0;
    return s[3] ? -(m * p) : (m * p);
  endfunction

  function automatic logic [QW-1:0] model(input int a, input int p0, input logic [3:0] s0,
                                          input int p1, input logic [3:0] s1, input bit d);
    int t = a + term_val(p0, s0) + (d ? term_val(p1, s1) : 0);
    return QW'(t & MASK);
  endfunction

  task automatic chk(input string req, input logic [QW-1:0] act, input logic [QW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at the falling edge, load at the rising edge, sample just after it
  task automatic step(input bit d, input logic [QW-1:0] a, input logic [QW-1:0] p0,
                      input logic [3:0] s0, input logic [QW-1:0] p1, input logic [3:0] s1,
                      input string req);
    @(negedge clk);
    en = 1'b1; dual_en = d; acc_in = a; pub0 = p0; sec0 = s0; pub1 = p1; sec1 = s1;
    @(posedge clk); #2;
    chk(req, acc_out, model(int'(a), int'(p0), s0, int'(p1), s1, d));
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; acc_in = 13'd777; pub0 = 13'd5; sec0 = 4'b0101;
    @(posedge clk); #2;
    chk("R8 reset", acc_out, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_single_sweep();
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 4; r++)
        step(1'b0, QW'($urandom), QW'($urandom), 4'(s), QW'($urandom), 4'($urandom),
             (s[2:0] > 5 || s[2:0] == 0) ? "R3 null magnitude" : "R1 R2 single term");
  endtask

  task automatic test_neg_zero();
    for (int r = 0; r < 6; r++)
      step(1'b0, QW'($urandom), QW'($urandom), 4'b1000, 13'd0, 4'b0000, "R4 negative zero");
  endtask

  task automatic test_dual_sweep();
    for (int s0v = 0; s0v < 16; s0v++)
      for (int s1v = 0; s1v < 16; s1v++)
        step(1'b1, QW'($urandom), QW'($urandom), 4'(s0v), QW'($urandom), 4'(s1v), "R5 dual term");
  endtask

  task automatic test_second_ignored();
    for (int r = 0; r < 8; r++)
      step(1'b0, 13'd100, 13'd7, 4'b0010, QW'($urandom), 4'b0101, "R6 second pair ignored");
  endtask

  task automatic test_wrap();
    step(1'b0, 13'd8191, 13'd8191, 4'b0101, 13'd0, 4'd0, "R7 overflow wrap");
    step(1'b0, 13'd0,    13'd1,    4'b1001, 13'd0, 4'd0, "R7 underflow wrap");
    step(1'b1, 13'd8000, 13'd4000, 4'b0101, 13'd4000, 4'b0101, "R7 dual overflow");
  endtask

  task automatic test_hold();
    logic [QW-1:0] held;
    step(1'b0, 13'd1234, 13'd10, 4'b0011, 13'd0, 4'd0, "R9 load");
    held = acc_out;
    @(negedge clk);
    en = 1'b0; acc_in = 13'd4321; pub0 = 13'd99; sec0 = 4'b0101;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 hold while disabled", acc_out, held);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; dual_en = 1'b0;
    pub0 = '0; pub1 = '0; sec0 = '0; sec1 = '0; acc_in = '0;
    repeat (2) @(posedge clk);
    test_reset();
    test_single_sweep();
    test_neg_zero();
    test_dual_sweep();
    test_second_ignored();
    test_wrap();
    test_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule